// File: doc/BRIEF.md
# Buffered Serial Peripheral Slave Port

This block is a slave-side synchronous serial port. An external master supplies the serial clock, the data-in line and an active-low select. The port returns data on its data-out line. A single-entry transmit holding register feeds a shift register. The shift register then feeds a single-entry receive holding register. The system clock runs well above the serial clock, so all three pins are brought into the system domain through two-flop synchronizers, and serial clock edges are detected there. Fixed mode: the data-out line changes after falling edges, data-in is sampled on rising edges, and the most significant bit is sent first.

Software reaches the port through a small register bus with a write strobe, a read strobe and a combinational read path. It programs the character length and loads outgoing words. It collects incoming words. It watches four status flags that gate a single interrupt output. Each flag is cleared in its own way: by writing new transmit data, by reading the received word, or by writing a 1 to the flag bit. A busy bit reports an active selection. Clearing the enable bit halts the shift engine.

Top module: `spi_slave_buf`

## Requirements
- R1: The mode register (address 1, bits 3:0) holds a length field L. A character is L+1 bits, and L=0 gives 2 bits. Received words read back right-aligned with the upper bits zero.
- R2: Flag bit 0 (transmit empty) is 1 after reset. It sets when the holding word moves into the shift register and clears on a write to the transmit register (address 2). The write wins when both happen in one cycle.
- R3: Flag bit 1 (receive full) sets when a completed character moves into the receive register (address 3). It clears on a read of address 3.
- R4: Flag bit 3 (overrun) sets when a character completes while receive full is 1 and the receive register is not being read. It clears only when a 1 is written to bit 3 of the flag register (address 4). Writing a 1 to bits 0, 1 or 4 has no effect.
- R5: Flag bit 2 (end of transmission) sets when a character completes while transmit empty is 1. It clears when a 1 is written to bit 2 of address 4.
- R6: The interrupt output is high exactly when a flag bit 3:0 is set and its matching bit in the enable register (address 5, bits 3:0) is set.
- R7: With control bit 0 (address 0) at 0, the port ignores the serial pins: no flag or buffer changes, the data-out line is 0, and the busy bit is 0.
- R8: Flag bit 4 (busy, read-only) is 1 while the port is enabled and selected.
- R9: The data-out line presents the transmit word MSB first within the programmed length. Each new character is reloaded from the holding register after the last falling edge, so characters can run back to back under one selection.
- R10: On overrun, the new character is dropped and the receive register keeps the older unread word.
- R11: Releasing the select in mid-character resets the bit counter. The partial character changes no flag and no buffer.
- R12: A pin change is acted on at the third system clock rising edge after it. A receive read in the same cycle as character completion returns the older word, keeps receive full set with the new word stored, and raises no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (for read side effects) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| sclk_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Select from master, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two events can land on one system clock edge: a software read of the receive register, and completion of a character with the receive register still full. The bench lets the final rising serial edge ripple through the synchronizers and times the bus read strobe to the third system clock edge after that pin change. It then expects the old word on the read bus, the new word stored with receive full still set, and overrun clear. The same kind of overlap is set up on the transmit side: a holding-register write made while a character is being shifted must suppress end of transmission for that character.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef enum logic [2:0] {
    REG_CTL  = 3'd0,
    REG_MODE = 3'd1,
    REG_TXD  = 3'd2,
    REG_RXD  = 3'd3,
    REG_FLAG = 3'd4,
    REG_IEN  = 3'd5
  } reg_addr_e;

  localparam int NFLAG  = 4;
  localparam int F_TBE  = 0;
  localparam int F_RBF  = 1;
  localparam int F_TEND = 2;
  localparam int F_OVR  = 3;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int         N   = 3,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST[g]}};
      else         ff <= {ff[0], d_i[g]};
    end
    assign q_o[g] = ff[1];
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 16,
  parameter int LW = 4,
  localparam int CW = $clog2(DW) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mosi_i,
  input  logic [LW-1:0] len_field_i,
  input  logic [DW-1:0] tx_word_i,
  output logic          load_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          miso_o,
  output logic [CW-1:0] bit_cnt_o
);
  logic [CW-1:0] char_len, bit_cnt;
  logic [DW-1:0] tx_sh, rx_sh, rx_next;
  logic          loaded, wrap, active, last;

  always_comb begin
    char_len = (len_field_i == '0) ? CW'(2) : CW'(len_field_i) + CW'(1);
    active   = en_i && sel_i;
    last     = (bit_cnt == char_len - CW'(1));
    rx_next  = {rx_sh[DW-2:0], mosi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      loaded  <= 1'b0;
      wrap    <= 1'b0;
    end else if (!active) begin
      bit_cnt <= '0;
      loaded  <= 1'b0;
      wrap    <= 1'b0;
    end else if (!loaded) begin
      tx_sh  <= tx_word_i << (CW'(DW) - char_len);  // MSB-align the character
      loaded <= 1'b1;
    end else if (rise_i) begin
      rx_sh <= rx_next;
      if (last) begin
        bit_cnt <= '0;
        wrap    <= 1'b1;
      end else begin
        bit_cnt <= bit_cnt + CW'(1);
      end
    end else if (fall_i) begin
      if (wrap) begin
        loaded <= 1'b0;  // reload on the following cycle
        wrap   <= 1'b0;
      end else begin
        tx_sh <= tx_sh << 1;
      end
    end
  end

  assign load_o    = active && !loaded;
  assign done_o    = active && loaded && rise_i && last;
  assign rx_word_o = rx_next & ({DW{1'b1}} >> (CW'(DW) - char_len));
  assign miso_o    = active ? tx_sh[DW-1] : 1'b0;
  assign bit_cnt_o = bit_cnt;
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_slave_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             done_i,
  input  logic             tx_wr_i,
  input  logic             rx_rd_i,
  input  logic [NFLAG-1:0] w1c_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             rx_take_o
);
  logic tbe, rbf, tend, ovr;

  assign rx_take_o = done_i && (!rbf || rx_rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbe  <= 1'b1;
      rbf  <= 1'b0;
      tend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (tx_wr_i)     tbe <= 1'b0;
      else if (load_i) tbe <= 1'b1;

      if (rx_take_o)    rbf <= 1'b1;
      else if (rx_rd_i) rbf <= 1'b0;

      if (done_i && tbe)      tend <= 1'b1;
      else if (w1c_i[F_TEND]) tend <= 1'b0;

      if (done_i && rbf && !rx_rd_i) ovr <= 1'b1;
      else if (w1c_i[F_OVR])         ovr <= 1'b0;
    end
  end

  always_comb begin
    flags_o         = '0;
    flags_o[F_TBE]  = tbe;
    flags_o[F_RBF]  = rbf;
    flags_o[F_TEND] = tend;
    flags_o[F_OVR]  = ovr;
  end
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
  import spi_slave_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 4,
  localparam int CW = $clog2(DW) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          irq_o
);
  logic [2:0]       pin_s;
  logic             sclk_s, sclk_d, mosi_s, sel, rise, fall;
  logic             en, busy, load, done, rx_take;
  logic [LW-1:0]    len_field;
  logic [DW-1:0]    tx_buf, rx_buf, rx_word;
  logic [NFLAG-1:0] ien, flags, w1c;
  logic [CW-1:0]    bit_cnt;
  logic             tx_wr, rx_rd, flag_wr;

  spi_in_sync #(.N(3), .RST(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, cs_ni, sclk_i}),
    .q_o   (pin_s)
  );

  assign sclk_s = pin_s[0];
  assign sel    = !pin_s[1];
  assign mosi_s = pin_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign rise = sclk_s && !sclk_d;
  assign fall = !sclk_s && sclk_d;

  assign tx_wr   = wr_en_i && (addr_i == REG_TXD);
  assign rx_rd   = rd_en_i && (addr_i == REG_RXD);
  assign flag_wr = wr_en_i && (addr_i == REG_FLAG);
  assign w1c     = flag_wr ? wdata_i[NFLAG-1:0] : '0;
  assign busy    = en && sel;

  spi_shift_core #(.DW(DW), .LW(LW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .sel_i      (sel),
    .rise_i     (rise),
    .fall_i     (fall),
    .mosi_i     (mosi_s),
    .len_field_i(len_field),
    .tx_word_i  (tx_buf),
    .load_o     (load),
    .done_o     (done),
    .rx_word_o  (rx_word),
    .miso_o     (miso_o),
    .bit_cnt_o  (bit_cnt)
  );

  spi_flag_unit u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .done_i   (done),
    .tx_wr_i  (tx_wr),
    .rx_rd_i  (rx_rd),
    .w1c_i    (w1c),
    .flags_o  (flags),
    .rx_take_o(rx_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en        <= 1'b0;
      len_field <= LW'(7);
      tx_buf    <= '0;
      rx_buf    <= '0;
      ien       <= '0;
    end else begin
      if (wr_en_i && addr_i == REG_CTL)  en        <= wdata_i[0];
      if (wr_en_i && addr_i == REG_MODE) len_field <= wdata_i[LW-1:0];
      if (wr_en_i && addr_i == REG_IEN)  ien       <= wdata_i[NFLAG-1:0];
      if (tx_wr)                         tx_buf    <= wdata_i;
      if (rx_take)                       rx_buf    <= rx_word;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTL:  rdata_o = DW'(en);
      REG_MODE: rdata_o = DW'(len_field);
      REG_TXD:  rdata_o = tx_buf;
      REG_RXD:  rdata_o = rx_buf;
      REG_FLAG: rdata_o = DW'({busy, flags});
      REG_IEN:  rdata_o = DW'(ien);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(flags & ien);
endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk
  import spi_slave_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             en,
  input logic             sel,
  input logic             done,
  input logic             tx_wr,
  input logic             rx_rd,
  input logic [NFLAG-1:0] w1c,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] ien,
  input logic [DW-1:0]    rx_buf,
  input logic [CW-1:0]    bit_cnt
);
  AST_TBE_CLR_ON_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr |=> !flags[F_TBE]);  // R2
  AST_RBF_CLR_ON_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd && !done |=> !flags[F_RBF]);  // R3
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags[F_OVR] && !w1c[F_OVR] |=> flags[F_OVR]);  // R4
  AST_OVR_KEEPS_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && flags[F_RBF] && !rx_rd |=> $stable(rx_buf));  // R10
  AST_TEND_NEEDS_TBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_TEND]) |-> $past(flags[F_TBE]) && $past(done));  // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == '0) |-> !irq_o);  // R6
  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> bit_cnt == '0);  // R7
  AST_PARTIAL_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> bit_cnt == '0 && !done);  // R11
endmodule

bind spi_slave_buf spi_slave_buf_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_o  (irq_o),
  .en     (en),
  .sel    (sel),
  .done   (done),
  .tx_wr  (tx_wr),
  .rx_rd  (rx_rd),
  .w1c    (w1c),
  .flags  (flags),
  .ien    (ien),
  .rx_buf (rx_buf),
  .bit_cnt(bit_cnt)
);

// File: tb/spi_slave_buf_bench.sv
`timescale 1ns/1ps
module spi_slave_buf_bench;
  localparam int HALF = 8;
  localparam logic [2:0] A_CTL = 3'd0, A_MODE = 3'd1, A_TXD = 3'd2,
                         A_RXD = 3'd3, A_FLAG = 3'd4, A_IEN = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso, irq;

  int total = 0, bad = 0;
  bit quiet = 1'b0;

  // behavioural reference state
  bit m_tbe = 1, m_rbf = 0, m_tend = 0, m_ovr = 0;
  logic [15:0] m_rx = '0;
  logic [3:0]  m_ien = '0;
  logic [15:0] col_data = '0;

  always #4 clk = ~clk;

  spi_slave_buf u_spi_slave_buf (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_i(sclk), .cs_ni(cs_n),
    .mosi_i(mosi), .miso_o(miso), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] mflags();
    return {m_ovr, m_tend, m_rbf, m_tbe};
  endfunction

  // every-clock comparison of the interrupt against the model (R6)
  always @(negedge clk) begin
    #1;
    if (quiet && rst_n) chk("R6 irq per clock", 16'(irq), 16'(|(mflags() & m_ien)));
  end

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    quiet = 0;
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
    if (a == A_TXD) m_tbe = 0;
    if (a == A_IEN) m_ien = d[3:0];
    if (a == A_FLAG) begin
      if (d[2]) m_tend = 0;
      if (d[3]) m_ovr = 0;
    end
    quiet = 1;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    quiet = 0;
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
    if (a == A_RXD) m_rbf = 0;
    quiet = 1;
  endtask

  task automatic chk_flags(input string r, input bit busy);
    logic [15:0] v;
    bus_rd(A_FLAG, v);
    chk(r, v, {11'd0, busy, mflags()});
  endtask

  // model of a completed character
  task automatic model_done(input logic [15:0] rxv, input bit col);
    if (m_tbe) m_tend = 1;
    if (m_rbf && !col) m_ovr = 1;
    else begin m_rx = rxv; m_rbf = 1; end
  endtask

  task automatic sel_on(input bit en);
    quiet = 0;
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
    if (en) m_tbe = 1;  // holding word moved to shifter
    quiet = 1;
  endtask

  task automatic sel_off();
    quiet = 0;
    @(negedge clk); cs_n = 1;
    repeat (HALF) @(negedge clk);
    quiet = 1;
  endtask

  task automatic spi_char(input logic [15:0] rxv, input int len, input bit col,
                          output logic [15:0] got);
    quiet = 0;
    got = '0;
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); mosi = rxv[i];
      repeat (HALF) @(negedge clk);
      got[i] = miso;
      sclk = 1;
      if (i == 0 && col) begin
        @(negedge clk); @(negedge clk);  // third edge after the pin change
        addr = A_RXD; rd = 1; #1 col_data = rdata;
        @(negedge clk); rd = 0;
        repeat (HALF - 3) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  logic [15:0] v, got;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    quiet = 1;

    chk_flags("R2 reset flags", 0);
    bus_rd(A_CTL, v); chk("R7 reset ctl", v, 16'h0);
    chk("R6 reset irq", 16'(irq), 16'h0);

    bus_wr(A_CTL, 16'h1);
    bus_wr(A_MODE, 16'h7);
    bus_wr(A_IEN, 16'hF);
    chk("R6 irq on tbe", 16'(irq), 16'h1);
    bus_wr(A_TXD, 16'h00A5);
    chk_flags("R2 tbe cleared by write", 0);

    // basic 8-bit character
    sel_on(1);
    chk_flags("R8 busy while selected", 1);
    spi_char(16'h003C, 8, 0, got);
    model_done(16'h003C, 0);
    chk("R9 miso msb first", got, 16'h00A5);
    sel_off();
    chk_flags("R3 R5 flags after char", 0);
    bus_rd(A_RXD, v); chk("R3 rx word", v, 16'h003C);
    chk_flags("R3 rbf cleared by read", 0);
    bus_wr(A_FLAG, 16'h0013);
    chk_flags("R4 w1c on tbe/rbf/busy ignored", 0);
    bus_wr(A_FLAG, 16'h0004);
    chk_flags("R5 tend w1c", 0);

    // overrun keeps old data
    sel_on(1);
    spi_char(16'h0011, 8, 0, got); model_done(16'h0011, 0);
    spi_char(16'h0022, 8, 0, got); model_done(16'h0022, 0);
    sel_off();
    chk_flags("R4 overrun set", 0);
    bus_rd(A_RXD, v); chk("R10 old word kept", v, 16'h0011);
    bus_wr(A_FLAG, 16'h000C);
    chk_flags("R4 overrun w1c", 0);

    // 12-bit length
    bus_wr(A_MODE, 16'hB);
    bus_wr(A_TXD, 16'h0ABC);
    sel_on(1);
    spi_char(16'h05A3, 12, 0, got); model_done(16'h05A3, 0);
    sel_off();
    chk("R1 12-bit miso", got, 16'h0ABC);
    bus_rd(A_RXD, v); chk("R1 12-bit rx", v, 16'h05A3);

    // field 0 gives 2 bits
    bus_wr(A_MODE, 16'h0);
    bus_wr(A_TXD, 16'hFFF1);
    sel_on(1);
    spi_char(16'h0002, 2, 0, got); model_done(16'h0002, 0);
    sel_off();
    chk("R1 2-bit miso", got, 16'h0001);
    bus_rd(A_RXD, v); chk("R1 2-bit rx", v, 16'h0002);

    // 16-bit length
    bus_wr(A_MODE, 16'hF);
    bus_wr(A_TXD, 16'h8001);
    sel_on(1);
    spi_char(16'hC35A, 16, 0, got); model_done(16'hC35A, 0);
    sel_off();
    chk("R1 16-bit miso", got, 16'h8001);
    bus_rd(A_RXD, v); chk("R1 16-bit rx", v, 16'hC35A);
    bus_wr(A_FLAG, 16'h0004);

    // back to back, write during first char suppresses tend
    bus_wr(A_MODE, 16'h7);
    bus_wr(A_TXD, 16'h0096);
    sel_on(1);
    bus_wr(A_TXD, 16'h0069);
    spi_char(16'h0055, 8, 0, got); model_done(16'h0055, 0);
    m_tbe = 1;  // reload of second word
    chk("R9 first of pair", got, 16'h0096);
    chk_flags("R5 no tend with pending word", 1);
    bus_rd(A_RXD, v); chk("R3 first of pair rx", v, 16'h0055);
    spi_char(16'h00AA, 8, 0, got); model_done(16'h00AA, 0);
    chk("R9 second of pair", got, 16'h0069);
    chk_flags("R5 tend after second", 1);
    sel_off();

    // read in the completion cycle with receive full set
    bus_wr(A_FLAG, 16'h0004);
    sel_on(1);
    spi_char(16'h00E7, 8, 1, got); model_done(16'h00E7, 1);
    sel_off();
    chk("R12 collide read old", col_data, 16'h00AA);
    chk_flags("R12 no overrun on collide", 0);
    bus_rd(A_RXD, v); chk("R12 new word stored", v, 16'h00E7);

    // partial character
    bus_wr(A_FLAG, 16'h0004);
    sel_on(1);
    quiet = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); mosi = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1;
      repeat (HALF) @(negedge clk); sclk = 0;
    end
    sel_off();
    chk_flags("R11 partial char no flags", 0);
    sel_on(1);
    spi_char(16'h0081, 8, 0, got); model_done(16'h0081, 0);
    sel_off();
    bus_rd(A_RXD, v); chk("R11 counter restarted", v, 16'h0081);

    // disabled
    bus_wr(A_FLAG, 16'h0004);
    bus_wr(A_CTL, 16'h0);
    bus_wr(A_TXD, 16'h00FF);
    sel_on(0);
    chk_flags("R7 busy low when off", 0);
    spi_char(16'h0033, 8, 0, got);
    sel_off();
    chk("R7 miso low when off", got, 16'h0000);
    chk_flags("R7 flags untouched when off", 0);
    bus_rd(A_RXD, v); chk("R7 rx untouched when off", v, 16'h0081);

    bus_wr(A_IEN, 16'h0);
    chk("R6 irq masked", 16'(irq), 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule